// File: doc/BRIEF.md
# Fetch and Miss-Stall Sequencer

This block is the control sequencer of a single-issue processor that completes one instruction at a time. In the running state it asks for a 32-bit instruction word at an aligned address every cycle. On a hit it executes that word in the same cycle and steps the program counter pair. Decode, the caches and address translation live outside. They report back through the hit, miss, fault and instruction-kind inputs.

A miss on the instruction fetch parks the sequencer until a completion pulse arrives. The word returned alongside the miss is captured. After completion, one extra cycle executes the captured word with no new fetch. A miss on a data access parks it in a separate stall state that ends on the completion pulse. A switch-out request freezes the sequencer, and any completion pulse that arrives while frozen is dropped without effect. A context-status change event restarts the sequencer or idles it.

Counters track executed instructions, memory references, loads, and the total cycles spent in each kind of stall.

Top module: `fetch_stall_seq`

## Requirements
- R1: While reset is held, and after it is released, the state reads Idle. The `state_o` encoding is Idle=0, Running=1, FetchStall=2, FetchDone=3, DataStall=4, Parked=5. `pc` equals `RESET_PC` and `npc` equals `RESET_PC+4`. All counters are zero. `fetch_req`, `exec_en`, `trap_req` and `miss_err` are low. Assertion of `rst_n` acts at once. Release takes effect after two rising clock edges.
- R2: In Running, `fetch_req` is 1 and `fetch_addr` equals `pc` with bits [1:0] cleared. `fetch_size` is 4. If `ifetch_hit` is 1, then in that same cycle `exec_en` is 1 and `exec_inst` equals `fetch_data`.
- R3: After an execution without `fault`, `pc` takes the old `npc` on the next cycle, and `npc` grows by 4.
- R4: In Running with `ifetch_hit`=0, `exec_en` stays 0 and `pc` is unchanged. `fetch_data` from that cycle is captured, and the next state is FetchStall. No fetch is requested while stalled.
- R5: A `miss_done` pulse in FetchStall moves the state to FetchDone. In FetchDone, `fetch_req` is 0 and `exec_en` is 1 with `exec_inst` equal to the captured word. The state then returns to Running.
- R6: An execution with `is_memref`=1, `dacc_miss`=1 and `fault`=0 moves the state to DataStall. A `miss_done` pulse there returns it to Running.
- R7: When `miss_done` ends a stall, the matching counter (`istall_cyc` or `dstall_cyc`) increases by the number of cycles spent in that stall. The completion cycle is included, and the first stall cycle counts as 1.
- R8: A `miss_done` in Parked leaves the state, the stall counters and `miss_err` unchanged. A `miss_done` in Idle, Running or FetchDone raises `miss_err` for exactly the following cycle.
- R9: Every execution adds 1 to `inst_cnt`, even one that faults. `memref_cnt` and `load_cnt` add 1 when `is_memref` and `is_load` are 1, respectively.
- R10: An execution with `fault`=1 leaves `pc` and `npc` unchanged and does not enter DataStall. `trap_req` is 1 for exactly the following cycle.
- R11: `swout_req` moves the state to Parked, with priority over everything else. Otherwise `ctx_chg` moves it to Running when `ctx_active` is 1 and to Idle when it is 0, overriding any stall. Idle and Parked issue no fetch and no execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctx_active | input | 1 | Context status level, sampled on `ctx_chg` |
| ctx_chg | input | 1 | Context status change event |
| swout_req | input | 1 | Park request |
| ifetch_hit | input | 1 | Fetch result: 1 hit, 0 miss |
| fetch_data | input | INST_W | Instruction word returned for the fetch |
| is_memref | input | 1 | Executing word accesses memory |
| is_load | input | 1 | Executing word is a load |
| dacc_miss | input | 1 | Data access of the executing word missed |
| fault | input | 1 | Executing word faulted |
| miss_done | input | 1 | Miss completion pulse |
| fetch_req | output | 1 | Fetch request |
| fetch_addr | output | ADDR_W | Aligned fetch address |
| fetch_size | output | SZ_W | Fetch size in bytes (4) |
| exec_en | output | 1 | Execute the word on `exec_inst` this cycle |
| exec_inst | output | INST_W | Word to execute |
| pc | output | ADDR_W | Program counter |
| npc | output | ADDR_W | Next program counter |
| trap_req | output | 1 | One-cycle trap request after a fault |
| miss_err | output | 1 | One-cycle flag for an unexpected completion |
| state_o | output | 3 | Current state code |
| inst_cnt | output | CNT_W | Executed instructions |
| memref_cnt | output | CNT_W | Executed memory references |
| load_cnt | output | CNT_W | Executed loads |
| istall_cyc | output | CNT_W | Total fetch-stall cycles |
| dstall_cyc | output | CNT_W | Total data-stall cycles |

## Verification
A wrong state shows up at the ports in the very cycle it is entered. The fetch request and execute enable are decoded directly from the state, and `state_o` exposes it, so a stall that never ends or a missing FetchDone cycle is visible at once. A wrong stall-age count appears only when the completion pulse adds it to a stall counter, which is why each stall test ends its stall on a cycle other than the first. PC errors appear one cycle after the execution that caused them.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RUN    = 3'd1,
    ST_ISTALL = 3'd2,
    ST_ICOMP  = 3'd3,
    ST_DSTALL = 3'd4,
    ST_PARK   = 3'd5
  } seq_state_e;
endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctx_active,
  input  logic             ctx_chg,
  input  logic             swout_req,
  input  logic             ifetch_hit,
  input  logic             is_memref,
  input  logic             dacc_miss,
  input  logic             fault,
  input  logic             miss_done,
  output seq_state_e       state,
  output logic             fetch_req,
  output logic             exec_en,
  output logic             capture,
  output logic             ist_done,
  output logic             dst_done,
  output logic [CNT_W-1:0] age,
  output logic             trap_req,
  output logic             miss_err
);
  seq_state_e       state_d;
  logic [CNT_W-1:0] age_d;
  logic             trap_d, err_d, dgo, in_stall;

  always_comb begin
    fetch_req = (state == ST_RUN);
    capture   = fetch_req & ~ifetch_hit;
    exec_en   = (fetch_req & ifetch_hit) | (state == ST_ICOMP);
    dgo       = exec_en & ~fault & is_memref & dacc_miss;
    ist_done  = (state == ST_ISTALL) & miss_done;
    dst_done  = (state == ST_DSTALL) & miss_done;
    in_stall  = (state == ST_ISTALL) | (state == ST_DSTALL);
    age_d     = in_stall ? age + 1'b1 : {{(CNT_W-1){1'b0}}, 1'b1};
    trap_d    = exec_en & fault;
    err_d     = miss_done & ((state == ST_IDLE) | (state == ST_RUN) | (state == ST_ICOMP));

    state_d = state;
    if (swout_req) begin
      state_d = ST_PARK;
    end else if (ctx_chg) begin
      state_d = ctx_active ? ST_RUN : ST_IDLE;
    end else begin
      case (state)
        ST_RUN: begin
          if (!ifetch_hit) state_d = ST_ISTALL;
          else if (dgo)    state_d = ST_DSTALL;
        end
        ST_ISTALL: if (miss_done) state_d = ST_ICOMP;
        ST_ICOMP:  state_d = dgo ? ST_DSTALL : ST_RUN;
        ST_DSTALL: if (miss_done) state_d = ST_RUN;
        default:   state_d = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      age      <= '0;
      trap_req <= 1'b0;
      miss_err <= 1'b0;
    end else begin
      state    <= state_d;
      age      <= age_d;
      trap_req <= trap_d;
      miss_err <= err_d;
    end
  end
endmodule

// File: rtl/seq_pc.sv
module seq_pc #(
  parameter int          ADDR_W   = 32,
  parameter int          STEP     = 4,
  parameter logic [31:0] RESET_PC = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] npc
);
  localparam logic [ADDR_W-1:0] PC0  = ADDR_W'(RESET_PC);
  localparam logic [ADDR_W-1:0] INC  = ADDR_W'(STEP);

  logic [ADDR_W-1:0] pc_d, npc_d;

  always_comb begin
    pc_d  = pc;
    npc_d = npc;
    if (advance) begin
      pc_d  = npc;
      npc_d = npc + INC;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= PC0;
      npc <= PC0 + INC;
    end else begin
      pc  <= pc_d;
      npc <= npc_d;
    end
  end
endmodule

// File: rtl/seq_counters.sv
module seq_counters #(
  parameter int CNT_W = 32,
  parameter int N_EV  = 3,
  parameter int N_ACC = 2,
  localparam int N_ALL = N_EV + N_ACC
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_ALL-1:0]            en,
  input  logic [CNT_W-1:0]            age,
  output logic [N_ALL-1:0][CNT_W-1:0] cnt
);
  for (genvar g = 0; g < N_ALL; g++) begin : g_cnt
    logic [CNT_W-1:0] amt, cnt_d;
    if (g < N_EV) begin : g_ev
      assign amt = {{(CNT_W-1){1'b0}}, 1'b1};
    end else begin : g_acc
      assign amt = age;
    end

    always_comb cnt_d = en[g] ? cnt[g] + amt : cnt[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt[g] <= '0;
      else        cnt[g] <= cnt_d;
    end
  end
endmodule

// File: rtl/fetch_stall_seq.sv
module fetch_stall_seq
  import seq_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int          INST_W   = 32,
  parameter int          CNT_W    = 32,
  parameter logic [31:0] RESET_PC = 32'h0000_1000,
  localparam int         SZ_W     = $clog2(INST_W/8) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctx_active,
  input  logic              ctx_chg,
  input  logic              swout_req,
  input  logic              ifetch_hit,
  input  logic [INST_W-1:0] fetch_data,
  input  logic              is_memref,
  input  logic              is_load,
  input  logic              dacc_miss,
  input  logic              fault,
  input  logic              miss_done,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [SZ_W-1:0]   fetch_size,
  output logic              exec_en,
  output logic [INST_W-1:0] exec_inst,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] npc,
  output logic              trap_req,
  output logic              miss_err,
  output logic [2:0]        state_o,
  output logic [CNT_W-1:0]  inst_cnt,
  output logic [CNT_W-1:0]  memref_cnt,
  output logic [CNT_W-1:0]  load_cnt,
  output logic [CNT_W-1:0]  istall_cyc,
  output logic [CNT_W-1:0]  dstall_cyc
);
  localparam int INST_BYTES = INST_W / 8;
  localparam int ALIGN      = $clog2(INST_BYTES);

  logic                  rst_sync_n;
  seq_state_e            state;
  logic                  capture, ist_done, dst_done;
  logic [CNT_W-1:0]      age;
  logic [INST_W-1:0]     held_q, held_d;
  logic [4:0][CNT_W-1:0] cnt;

  seq_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .ctx_active(ctx_active), .ctx_chg(ctx_chg), .swout_req(swout_req),
    .ifetch_hit(ifetch_hit), .is_memref(is_memref), .dacc_miss(dacc_miss),
    .fault(fault), .miss_done(miss_done),
    .state(state), .fetch_req(fetch_req), .exec_en(exec_en),
    .capture(capture), .ist_done(ist_done), .dst_done(dst_done),
    .age(age), .trap_req(trap_req), .miss_err(miss_err)
  );

  seq_pc #(.ADDR_W(ADDR_W), .STEP(INST_BYTES), .RESET_PC(RESET_PC)) u_pc (
    .clk(clk), .rst_n(rst_sync_n), .advance(exec_en & ~fault),
    .pc(pc), .npc(npc)
  );

  seq_counters #(.CNT_W(CNT_W), .N_EV(3), .N_ACC(2)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n),
    .en({dst_done, ist_done, exec_en & is_load, exec_en & is_memref, exec_en}),
    .age(age), .cnt(cnt)
  );

  always_comb held_d = capture ? fetch_data : held_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) held_q <= '0;
    else             held_q <= held_d;
  end

  assign fetch_addr = {pc[ADDR_W-1:ALIGN], {ALIGN{1'b0}}};
  assign fetch_size = SZ_W'(INST_BYTES);
  assign exec_inst  = (state == ST_ICOMP) ? held_q : fetch_data;
  assign state_o    = state;
  assign inst_cnt   = cnt[0];
  assign memref_cnt = cnt[1];
  assign load_cnt   = cnt[2];
  assign istall_cyc = cnt[3];
  assign dstall_cyc = cnt[4];
endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              ctx_chg,
  input logic              swout_req,
  input logic              miss_done,
  input logic              fault,
  input logic              exec_en,
  input logic              fetch_req,
  input logic [2:0]        state_o,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] npc,
  input logic              trap_req,
  input logic              miss_err,
  input logic [CNT_W-1:0]  inst_cnt
);
  // R2
  fetch_only_running_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fetch_req |-> state_o == 3'd1);

  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_en && !fault) |=> (pc == $past(npc)) && (npc == $past(npc) + 3'd4));

  // R10
  fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (exec_en && fault) |=> $stable(pc) && $stable(npc) && trap_req);

  // R5
  fetch_done_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_o == 3'd2 && miss_done && !swout_req && !ctx_chg) |=> (state_o == 3'd3) && !fetch_req && exec_en);

  // R8
  parked_drop_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (state_o == 3'd5 && miss_done && !ctx_chg) |=> (state_o == 3'd5) && !miss_err);

  // R9
  inst_count_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    exec_en |=> inst_cnt == $past(inst_cnt) + 1'b1);

  // R11
  park_priority_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    swout_req |=> state_o == 3'd5);
endmodule

bind fetch_stall_seq seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .ctx_chg(ctx_chg), .swout_req(swout_req),
  .miss_done(miss_done), .fault(fault), .exec_en(exec_en), .fetch_req(fetch_req),
  .state_o(state_o), .pc(pc), .npc(npc), .trap_req(trap_req),
  .miss_err(miss_err), .inst_cnt(inst_cnt)
);

// File: tb/sim_fetch_stall_seq.sv
`timescale 1ns/1ps
module sim_fetch_stall_seq;
  localparam logic [31:0] RP = 32'h0000_1002;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctx_active, ctx_chg, swout_req, ifetch_hit;
  logic [31:0] fetch_data;
  logic        is_memref, is_load, dacc_miss, fault, miss_done;
  logic        fetch_req, exec_en, trap_req, miss_err;
  logic [31:0] fetch_addr, exec_inst, pc, npc;
  logic [2:0]  fetch_size, state_o;
  logic [31:0] inst_cnt, memref_cnt, load_cnt, istall_cyc, dstall_cyc;

  int total = 0;
  int bad   = 0;
  logic [31:0] e_pc, e_npc, e_inst, e_mref, e_load, e_ist, e_dst;

  always #2.5 clk = ~clk;

  fetch_stall_seq #(.RESET_PC(RP)) u0 (
    .clk(clk), .rst_n(rst_n), .ctx_active(ctx_active), .ctx_chg(ctx_chg),
    .swout_req(swout_req), .ifetch_hit(ifetch_hit), .fetch_data(fetch_data),
    .is_memref(is_memref), .is_load(is_load), .dacc_miss(dacc_miss),
    .fault(fault), .miss_done(miss_done), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .fetch_size(fetch_size), .exec_en(exec_en),
    .exec_inst(exec_inst), .pc(pc), .npc(npc), .trap_req(trap_req),
    .miss_err(miss_err), .state_o(state_o), .inst_cnt(inst_cnt),
    .memref_cnt(memref_cnt), .load_cnt(load_cnt), .istall_cyc(istall_cyc),
    .dstall_cyc(dstall_cyc)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    ctx_chg = 0; swout_req = 0; ifetch_hit = 0; is_memref = 0; is_load = 0;
    dacc_miss = 0; fault = 0; miss_done = 0; fetch_data = '0;
  endtask

  task automatic check_counts(input string req);
    check({req, " inst"}, inst_cnt, e_inst);
    check({req, " memref"}, memref_cnt, e_mref);
    check({req, " load"}, load_cnt, e_load);
    check({req, " istall"}, istall_cyc, e_ist);
    check({req, " dstall"}, dstall_cyc, e_dst);
  endtask

  task automatic t_reset();
    rst_n = 0; ctx_active = 0; idle_inputs();
    repeat (3) step();
    check("R1 state in reset", state_o, 0);
    rst_n = 1;
    repeat (3) step();
    e_pc = RP; e_npc = RP + 4;
    e_inst = 0; e_mref = 0; e_load = 0; e_ist = 0; e_dst = 0;
    check("R1 state", state_o, 0);
    check("R1 pc", pc, e_pc);
    check("R1 npc", npc, e_npc);
    check("R1 flags", {fetch_req, exec_en, trap_req, miss_err}, 0);
    check_counts("R1");
  endtask

  task automatic t_run();
    ctx_active = 1; ctx_chg = 1;
    step();
    ctx_chg = 0;
    check("R11 ctx to running", state_o, 1);
    ifetch_hit = 1; fetch_data = 32'hA5A5_0001; is_memref = 1; is_load = 1;
    #0.5;
    check("R2 fetch_req", fetch_req, 1);
    check("R2 fetch_addr aligned", fetch_addr, {e_pc[31:2], 2'b00});
    check("R2 fetch_size", fetch_size, 4);
    check("R2 exec_en", exec_en, 1);
    check("R2 exec_inst", exec_inst, 32'hA5A5_0001);
    step();
    e_pc = e_npc; e_npc = e_npc + 4; e_inst++; e_mref++; e_load++;
    check("R3 pc", pc, e_pc);
    check("R3 npc", npc, e_npc);
    check_counts("R9");
    is_load = 0;
    for (int i = 0; i < 3; i++) begin
      is_memref = (i == 1);
      fetch_data = 32'h100 + i;
      #0.5 check("R2 fetch_addr loop", fetch_addr, {e_pc[31:2], 2'b00});
      step();
      e_pc = e_npc; e_npc = e_npc + 4; e_inst++;
      if (i == 1) e_mref++;
    end
    is_memref = 0;
    check("R3 pc after run", pc, e_pc);
    check_counts("R9 after run");
  endtask

  task automatic t_imiss();
    ifetch_hit = 0; fetch_data = 32'hDEAD_BEEF;
    #0.5 check("R4 no exec on miss", exec_en, 0);
    step();
    ifetch_hit = 1; fetch_data = 32'h1111_2222;
    check("R4 state stall", state_o, 2);
    check("R4 pc held", pc, e_pc);
    #0.5 check("R4 no fetch in stall", {fetch_req, exec_en}, 0);
    step();
    step();
    miss_done = 1;
    step();
    miss_done = 0;
    e_ist = e_ist + 3;
    check("R5 state fetchdone", state_o, 3);
    #0.5;
    check("R5 no refetch", fetch_req, 0);
    check("R5 exec held", exec_en, 1);
    check("R5 held word", exec_inst, 32'hDEAD_BEEF);
    check("R7 istall count", istall_cyc, e_ist);
    step();
    e_pc = e_npc; e_npc = e_npc + 4; e_inst++;
    check("R5 back to running", state_o, 1);
    check("R5 pc", pc, e_pc);
    check_counts("R5");
  endtask

  task automatic t_dmiss();
    ifetch_hit = 1; is_memref = 1; dacc_miss = 1; fetch_data = 32'h0D0D;
    step();
    is_memref = 0; dacc_miss = 0;
    e_pc = e_npc; e_npc = e_npc + 4; e_inst++; e_mref++;
    check("R6 state datastall", state_o, 4);
    check("R6 pc advanced", pc, e_pc);
    #0.5 check("R6 no fetch", fetch_req, 0);
    step();
    miss_done = 1;
    step();
    miss_done = 0;
    e_dst = e_dst + 2;
    check("R6 back to running", state_o, 1);
    check("R7 dstall count", dstall_cyc, e_dst);
    check_counts("R6");
  endtask

  task automatic t_fault();
    ifetch_hit = 1; fault = 1; is_memref = 1; dacc_miss = 1;
    step();
    fault = 0; is_memref = 0; dacc_miss = 0;
    e_inst++; e_mref++;
    check("R10 pc kept", pc, e_pc);
    check("R10 npc kept", npc, e_npc);
    check("R10 trap", trap_req, 1);
    check("R10 no datastall", state_o, 1);
    check_counts("R10 R9");
    step();
    e_pc = e_npc; e_npc = e_npc + 4; e_inst++;
    check("R10 trap one cycle", trap_req, 0);
    check("R3 pc after fault", pc, e_pc);
  endtask

  task automatic t_stray();
    ifetch_hit = 1; miss_done = 1;
    step();
    miss_done = 0;
    e_pc = e_npc; e_npc = e_npc + 4; e_inst++;
    check("R8 err raised", miss_err, 1);
    check("R8 state kept", state_o, 1);
    step();
    e_pc = e_npc; e_npc = e_npc + 4; e_inst++;
    check("R8 err one cycle", miss_err, 0);
    check_counts("R8 stray");
  endtask

  task automatic t_park();
    ifetch_hit = 0; swout_req = 1; ctx_chg = 1; ctx_active = 1;
    step();
    swout_req = 0; ctx_chg = 0;
    check("R11 park priority", state_o, 5);
    #0.5 check("R11 parked quiet", {fetch_req, exec_en}, 0);
    miss_done = 1;
    step();
    miss_done = 0;
    check("R8 parked state", state_o, 5);
    check("R8 parked no err", miss_err, 0);
    check_counts("R8 parked");
    check("R8 pc", pc, e_pc);
    ctx_active = 0; ctx_chg = 1;
    step();
    ctx_chg = 0;
    check("R11 to idle", state_o, 0);
    #0.5 check("R11 idle quiet", {fetch_req, exec_en}, 0);
    ctx_active = 1; ctx_chg = 1;
    step();
    ctx_chg = 0;
    check("R11 to running", state_o, 1);
  endtask

  task automatic t_async_reset();
    ifetch_hit = 1;
    step();
    ifetch_hit = 0;
    #1 rst_n = 0;
    #0.5;
    check("R1 async state", state_o, 0);
    check("R1 async pc", pc, RP);
    check("R1 async inst", inst_cnt, 0);
    #1 rst_n = 1;
    step();
    step();
    check("R1 held until sync", state_o, 0);
  endtask

  initial begin
    t_reset();
    t_run();
    t_imiss();
    t_dmiss();
    t_fault();
    t_stray();
    t_park();
    t_async_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule